// File: doc/BRIEF.md
# Five-State JK Flip-Flop Sequence Counter

This block is a free-running 3-bit synchronous counter. Its state bits are A (most significant), B and C, and it presents them as `state_q[2:0]` = {A, B, C}. On every rising clock edge it takes one step through a fixed five-code loop that is not in binary order. The counter has no enable and no data inputs.

Each state bit is stored in a behavioural JK flip-flop. The J and K inputs of every flip-flop come from a shared block of excitation logic. Each flip-flop also has an active-low asynchronous force-to-one input and an active-low asynchronous force-to-zero input. The surrounding logic uses these to place the counter in a known code, usually all zeros. Three codes are never part of the loop. If the counter lands in one of them, it rejoins the loop on the next clock edge.

Top module: `jk_seq_counter`

## Requirements
- R1: With every preset_n and clear_n bit high, each rising clock edge moves state_q (bit 2 = A, bit 1 = B, bit 0 = C) one step around the loop 000 → 100 → 111 → 010 → 011 → 000.
- R2: Driving clear_n[i] low forces state_q[i] to 0 without waiting for a clock edge.
- R3: Driving preset_n[i] low while clear_n[i] is high forces state_q[i] to 1 without waiting for a clock edge.
- R4: When preset_n[i] and clear_n[i] are both low, state_q[i] is 0.
- R5: While clear_n[i] or preset_n[i] is low, rising clock edges do not change state_q[i].
- R6: From the unused code 001, one rising edge gives 100.
- R7: From the unused code 101, one rising edge gives 111.
- R8: From the unused code 110, one rising edge gives 011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| preset_n | input | 3 | Active-low asynchronous force-to-one for each bit (bit 2 = A) |
| clear_n | input | 3 | Active-low asynchronous force-to-zero for each bit; wins over preset_n |
| state_q | output | 3 | Counter state {A, B, C} |

## Verification
The transition properties assume that the preset and clear inputs stay high for the whole clock interval they check. The checker therefore turns those properties off whenever any of these inputs is low. The bench changes preset and clear only at the falling edge of the clock. It holds them low across at least one rising edge and releases them at a later falling edge, so every checked interval has no asynchronous activity in it. The bench checks the forcing behaviour before the next rising edge and the step behaviour half a period after the edge.

// File: rtl/jk_seq_counter_pkg.sv
package jk_seq_counter_pkg;
  localparam int STATE_W = 3;
  localparam int BIT_A   = 2;
  localparam int BIT_B   = 1;
  localparam int BIT_C   = 0;
  typedef logic [STATE_W-1:0] state_t;
endpackage

// File: rtl/jk_ff.sv
module jk_ff (
  input  logic clk,
  input  logic pre_n,
  input  logic clr_n,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_next;

  // Next-state logic: hold, reset, set or toggle
  always_comb begin
    unique case ({j, k})
      2'b00:   q_next = q;
      2'b01:   q_next = 1'b0;
      2'b10:   q_next = 1'b1;
      default: q_next = ~q;
    endcase
  end

  // State register; the asynchronous clear is checked first so it wins
  always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
    if (!clr_n)      q <= 1'b0;
    else if (!pre_n) q <= 1'b1;
    else             q <= q_next;
  end
endmodule

// File: rtl/jk_seq_excite.sv
module jk_seq_excite
  import jk_seq_counter_pkg::*;
(
  input  state_t cur,
  output state_t j_vec,
  output state_t k_vec
);
  logic a, b, c;

  always_comb begin
    a = cur[BIT_A];
    b = cur[BIT_B];
    c = cur[BIT_C];
    // bit A: the next value is the inverse of B
    j_vec[BIT_A] = ~b;
    k_vec[BIT_A] = b;
    // bit B: next value is A OR (B AND NOT C)
    j_vec[BIT_B] = a;
    k_vec[BIT_B] = ~a & c;
    // bit C: next value is (A AND NOT B) OR (B AND NOT C)
    j_vec[BIT_C] = (a & ~b) | b;
    k_vec[BIT_C] = ~a | b;
  end
endmodule

// File: rtl/jk_seq_counter.sv
module jk_seq_counter
  import jk_seq_counter_pkg::*;
(
  input  logic               clk,
  input  logic [STATE_W-1:0] preset_n,
  input  logic [STATE_W-1:0] clear_n,
  output logic [STATE_W-1:0] state_q
);
  state_t j_vec;
  state_t k_vec;

  jk_seq_excite excite_i (
    .cur   (state_q),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar gi = 0; gi < STATE_W; gi++) begin : g_bit
    jk_ff ff_i (
      .clk   (clk),
      .pre_n (preset_n[gi]),
      .clr_n (clear_n[gi]),
      .j     (j_vec[gi]),
      .k     (k_vec[gi]),
      .q     (state_q[gi])
    );
  end
endmodule

// File: rtl/jk_seq_counter_chk.sv
module jk_seq_counter_chk
  import jk_seq_counter_pkg::*;
(
  input logic               clk,
  input logic [STATE_W-1:0] preset_n,
  input logic [STATE_W-1:0] clear_n,
  input logic [STATE_W-1:0] state_q
);
  logic init_act;
  assign init_act = ~(&preset_n) | ~(&clear_n);

  assert_loop_000_R1: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b000) |=> (state_q == 3'b100));
  assert_loop_100_R1: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b100) |=> (state_q == 3'b111));
  assert_loop_111_R1: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b111) |=> (state_q == 3'b010));
  assert_loop_010_R1: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b010) |=> (state_q == 3'b011));
  assert_loop_011_R1: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b011) |=> (state_q == 3'b000));
  assert_recover_001_R6: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b001) |=> (state_q == 3'b100));
  assert_recover_101_R7: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b101) |=> (state_q == 3'b111));
  assert_recover_110_R8: assert property (@(posedge clk) disable iff (init_act)
    (state_q == 3'b110) |=> (state_q == 3'b011));

  for (genvar gi = 0; gi < STATE_W; gi++) begin : g_bit_chk
    assert_clear_forces_R2: assert property (@(negedge clk)
      !clear_n[gi] |-> !state_q[gi]);
    assert_preset_forces_R3: assert property (@(negedge clk)
      (clear_n[gi] && !preset_n[gi]) |-> state_q[gi]);
    assert_clear_wins_R4: assert property (@(negedge clk)
      (!clear_n[gi] && !preset_n[gi]) |-> !state_q[gi]);
  end
endmodule

bind jk_seq_counter jk_seq_counter_chk chk_i (.*);

// File: tb/jk_seq_counter_tb.sv
`timescale 1ns/1ps
module jk_seq_counter_tb_top;
  logic       clk;
  logic [2:0] preset_n;
  logic [2:0] clear_n;
  logic [2:0] state_q;
  int checks;
  int errors;

  jk_seq_counter dut_i (
    .clk      (clk),
    .preset_n (preset_n),
    .clear_n  (clear_n),
    .state_q  (state_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2:0] model_next(input logic [2:0] s);
    logic a, b, c;
    a = s[2]; b = s[1]; c = s[0];
    return {~b, a | (b & ~c), (a & ~b) | (b & ~c)};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Force a code through the asynchronous inputs, hold it across a rising edge, release it
  task automatic load_code(input logic [2:0] code);
    @(negedge clk);
    clear_n  = code;
    preset_n = ~code;
    @(posedge clk);
    @(negedge clk);
    check("R5 load held", state_q, code);
    preset_n = 3'b111;
    clear_n  = 3'b111;
  endtask

  task automatic t_clear_async;
    @(negedge clk);
    clear_n = 3'b000;
    #1;
    check("R2 clear without edge", state_q, 3'b000);
    @(negedge clk);
    clear_n = 3'b111;
  endtask

  task automatic t_preset_async;
    @(negedge clk);
    preset_n = 3'b111 & 3'b101;
    clear_n  = 3'b000;
    @(negedge clk);
    clear_n  = 3'b111;
    preset_n = 3'b010;
    #1;
    check("R3 preset without edge", state_q, 3'b101);
    @(negedge clk);
    preset_n = 3'b111;
  endtask

  task automatic t_priority;
    @(negedge clk);
    preset_n = 3'b000;
    clear_n  = 3'b110;
    #1;
    check("R4 clear wins on bit C", state_q, 3'b110);
    @(posedge clk);
    @(negedge clk);
    check("R4 held across edge", state_q, 3'b110);
    preset_n = 3'b111;
    clear_n  = 3'b111;
  endtask

  task automatic t_hold;
    @(negedge clk);
    clear_n = 3'b000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R5 held in clear", state_q, 3'b000);
    end
    clear_n = 3'b111;
  endtask

  task automatic t_cycle;
    logic [2:0] exp;
    load_code(3'b000);
    exp = 3'b000;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk);
      @(negedge clk);
      exp = model_next(exp);
      check("R1 loop step", state_q, exp);
    end
  endtask

  task automatic t_recover(input string req, input logic [2:0] code, input logic [2:0] exp);
    load_code(code);
    @(posedge clk);
    @(negedge clk);
    check(req, state_q, exp);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    preset_n = 3'b111;
    clear_n  = 3'b000;
    #1;
    check("R2 reset state", state_q, 3'b000);
    @(negedge clk);
    clear_n = 3'b111;
    t_clear_async();
    t_preset_async();
    t_priority();
    t_hold();
    t_cycle();
    t_recover("R6 recover 001", 3'b001, 3'b100);
    t_recover("R7 recover 101", 3'b101, 3'b111);
    t_recover("R8 recover 110", 3'b110, 3'b011);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule